// File: doc/BRIEF.md
# Branch Resolution Unit

This unit resolves one branch instruction per clock for a 32-bit RISC core. It receives an instruction word together with the program counter and the current condition, count and link registers. It classifies the word as one of four branch shapes, or as no branch at all. It then decides whether control transfers and produces the next program counter. It also supplies write-back values and enables for the count and link registers.

Conditional shapes carry a 4-bit option code. The code says two things: whether the count register is decremented and tested, and whether one condition-register bit must read as set or as clear. A separate bit beside the code is a static prediction hint, and the unit passes it through. Option codes outside the defined set behave as "always branch" and raise a flag. All results appear one cycle after the input strobe and are accompanied by an output valid.

Top module: `bru_unit`

## Requirements
- R1: Results are registered. When `in_valid` is high at a rising edge, `out_valid` is high after that edge and the outputs describe that instruction. When `in_valid` is low at an edge, `out_valid`, `ctr_we` and `lr_we` are low after it. While `rst_n` is low, every output is zero.
- R2: The option code is `instr[25:22]` and the hint is `instr[21]`. The `hint` output copies `instr[21]` for the three conditional shapes and is 0 otherwise. The condition index is `instr[20:16]`, and an index of n reads `cr[31-n]`. Index 0 is therefore the "less than" bit of the first field, and index 2 is its "equal" bit.
- R3: The option codes have these meanings. 0010 branches when the selected bit is 0, and 0110 branches when it is 1. 1010 always branches. 1000 and 1001 decrement the count register and need the new count to be non-zero (1000) or zero (1001). 0000, 0001, 0100 and 0101 combine that count test (bit 0) with a bit test, where bit 2 = 1 requires the selected bit to be set and bit 2 = 0 requires it clear.
- R4: The count test uses the decremented value. When the option code asks for a decrement, `ctr_we` is 1 and `ctr_wdata` is `ctr-1`, whether the branch is taken or not.
- R5: Option codes 0011, 0111, 1011 and 11xx branch unconditionally, do not decrement the count register, and set `reserved`.
- R6: For the conditional relative shape, the offset is `instr[15:2]` followed by two zero bits, sign-extended from bit 15. The target is `pc+offset`, or the offset alone when `instr[1]` is set.
- R7: For the unconditional shape, the offset is `instr[25:2]` followed by two zero bits, sign-extended from bit 25. The target is `pc+offset`, or the offset alone when `instr[1]` is set.
- R8: The via-count shape jumps to `ctr` with its two low bits cleared. The via-link shape jumps to the incoming `lr` with its two low bits cleared.
- R9: When a branch word has `instr[0]` set, `lr_we` is 1 and `lr_wdata` is `pc+4`, whether the branch is taken or not.
- R10: When no transfer happens, `next_pc` is `pc+4` and `taken` is 0.
- R11: The shape is set by `instr[31:26]`. The value 18 is the unconditional shape and 16 is the conditional relative shape. The value 19 is the via-link shape when `instr[10:1]` is 16 and the via-count shape when it is 528. Any other word is not a branch: it is not taken, writes no register, and leaves `reserved` and `hint` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| cr | input | 32 | Condition register |
| ctr | input | 32 | Count register |
| lr | input | 32 | Link register |
| out_valid | output | 1 | Results valid |
| taken | output | 1 | Control transfers |
| next_pc | output | 32 | Next program counter |
| ctr_we | output | 1 | Count register write enable |
| ctr_wdata | output | 32 | New count value |
| lr_we | output | 1 | Link register write enable |
| lr_wdata | output | 32 | New link value |
| hint | output | 1 | Prediction hint, 1 means expect taken |
| reserved | output | 1 | Undefined option code seen |

## Verification
On every cycle, the assertions check the one-cycle output timing and the quiet outputs on idle cycles. They also check the decrement write-back, the link write-back of `pc+4`, the `pc+4` fall-through whenever the decision is "not taken", and that a reserved code always transfers. Only the bench's scenarios can show that each option code reaches the right decision for particular count and condition values. The same holds for the sign extension of negative displacements, the absolute and relative selection, the clearing of the low bits of register targets, and the rejection of words that merely resemble branches.

// File: rtl/bru_pkg.sv
package bru_pkg;

  localparam int XLEN   = 32;
  localparam int OPT_W  = 4;
  localparam int IDX_W  = 5;
  localparam int OPC_W  = 6;
  localparam int XO_W   = 10;
  localparam int STEP   = 4;

  localparam logic [OPC_W-1:0] OPC_DIRECT = 6'd18;
  localparam logic [OPC_W-1:0] OPC_COND   = 6'd16;
  localparam logic [OPC_W-1:0] OPC_EXT    = 6'd19;
  localparam logic [XO_W-1:0]  XO_VIA_LR  = 10'd16;
  localparam logic [XO_W-1:0]  XO_VIA_CTR = 10'd528;

  typedef enum logic [2:0] {
    FORM_NONE,
    FORM_DIRECT,
    FORM_COND,
    FORM_VIA_CTR,
    FORM_VIA_LR
  } form_e;

  typedef struct packed {
    logic ctr_dec;
    logic ctr_want_zero;
    logic use_cr;
    logic cr_want_set;
    logic rsvd;
  } opt_t;

  // Option code -> test recipe. Undefined codes give an empty recipe
  // (unconditional) plus the reserved marker.
  function automatic opt_t opt_decode(input logic [OPT_W-1:0] code);
    opt_t o;
    o = '0;
    case (code)
      4'b0000, 4'b0001, 4'b0100, 4'b0101, 4'b1000, 4'b1001: begin
        o.ctr_dec       = 1'b1;
        o.ctr_want_zero = code[0];
        o.use_cr        = ~code[3];
        o.cr_want_set   = code[2];
      end
      4'b0010, 4'b0110: begin
        o.use_cr      = 1'b1;
        o.cr_want_set = code[2];
      end
      4'b1010: o = '0;
      default: o.rsvd = 1'b1;
    endcase
    return o;
  endfunction

  function automatic logic [XLEN-1:0] cond_offset(input logic [31:0] iw);
    return {{(XLEN-16){iw[15]}}, iw[15:2], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] direct_offset(input logic [31:0] iw);
    return {{(XLEN-26){iw[25]}}, iw[25:2], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] word_align(input logic [XLEN-1:0] v);
    return {v[XLEN-1:2], 2'b00};
  endfunction

  // Bit numbering runs from the most significant end.
  function automatic logic cr_pick(input logic [XLEN-1:0] crv,
                                   input logic [IDX_W-1:0] idx);
    return crv[(XLEN-1) - int'(idx)];
  endfunction

endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
(
  input  logic [31:0]      iw,
  output form_e            form,
  output logic             is_cond,
  output opt_t             opt,
  output logic [IDX_W-1:0] cr_idx,
  output logic             hint,
  output logic             abs_sel,
  output logic             link
);

  logic [OPC_W-1:0] opc;
  logic [XO_W-1:0]  xo;

  assign opc = iw[31:26];
  assign xo  = iw[10:1];

  always_comb begin
    case (opc)
      OPC_DIRECT: form = FORM_DIRECT;
      OPC_COND:   form = FORM_COND;
      OPC_EXT: begin
        if (xo == XO_VIA_LR)       form = FORM_VIA_LR;
        else if (xo == XO_VIA_CTR) form = FORM_VIA_CTR;
        else                       form = FORM_NONE;
      end
      default:    form = FORM_NONE;
    endcase
  end

  assign is_cond = (form == FORM_COND) || (form == FORM_VIA_CTR) ||
                   (form == FORM_VIA_LR);
  assign opt     = is_cond ? opt_decode(iw[25:22]) : '0;
  assign cr_idx  = iw[20:16];
  assign hint    = is_cond & iw[21];
  assign abs_sel = iw[1] & ((form == FORM_DIRECT) || (form == FORM_COND));
  assign link    = (form != FORM_NONE) & iw[0];

endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
(
  input  form_e            form,
  input  logic             is_cond,
  input  opt_t             opt,
  input  logic [XLEN-1:0]  crv,
  input  logic [IDX_W-1:0] cr_idx,
  input  logic [XLEN-1:0]  ctr_in,
  output logic [XLEN-1:0]  ctr_next,
  output logic             dec_en,
  output logic             take
);

  logic ctr_ok;
  logic cr_ok;
  logic cr_bit;

  assign ctr_next = ctr_in - XLEN'(1);
  assign cr_bit   = cr_pick(crv, cr_idx);
  assign ctr_ok   = ~opt.ctr_dec | ((ctr_next == '0) == opt.ctr_want_zero);
  assign cr_ok    = ~opt.use_cr  | (cr_bit == opt.cr_want_set);
  assign dec_en   = is_cond & opt.ctr_dec;
  assign take     = (form == FORM_DIRECT) | (is_cond & ctr_ok & cr_ok);

endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_pkg::*;
(
  input  form_e           form,
  input  logic [31:0]     iw,
  input  logic            abs_sel,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] ctr_in,
  input  logic [XLEN-1:0] lr_in,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] seq_pc
);

  logic [XLEN-1:0] base;

  assign seq_pc = pc_in + XLEN'(STEP);
  assign base   = abs_sel ? '0 : pc_in;

  always_comb begin
    case (form)
      FORM_DIRECT:  target = base + direct_offset(iw);
      FORM_COND:    target = base + cond_offset(iw);
      FORM_VIA_CTR: target = word_align(ctr_in);
      FORM_VIA_LR:  target = word_align(lr_in);
      default:      target = seq_pc;
    endcase
  end

endmodule

// File: rtl/bru_unit.sv
module bru_unit
  import bru_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] cr,
  input  logic [XLEN-1:0] ctr,
  input  logic [XLEN-1:0] lr,
  output logic            out_valid,
  output logic            taken,
  output logic [XLEN-1:0] next_pc,
  output logic            ctr_we,
  output logic [XLEN-1:0] ctr_wdata,
  output logic            lr_we,
  output logic [XLEN-1:0] lr_wdata,
  output logic            hint,
  output logic            reserved
);

  form_e            form_w;
  logic             is_cond_w;
  opt_t             opt_w;
  logic [IDX_W-1:0] idx_w;
  logic             hint_w;
  logic             abs_w;
  logic             link_w;
  logic [XLEN-1:0]  ctr_next_w;
  logic             dec_en_w;
  logic             taken_w;
  logic [XLEN-1:0]  target_w;
  logic [XLEN-1:0]  seq_w;
  logic [XLEN-1:0]  npc_w;
  logic             rsvd_w;

  bru_decode u_dec (
    .iw      (instr),
    .form    (form_w),
    .is_cond (is_cond_w),
    .opt     (opt_w),
    .cr_idx  (idx_w),
    .hint    (hint_w),
    .abs_sel (abs_w),
    .link    (link_w)
  );

  bru_cond u_cond (
    .form     (form_w),
    .is_cond  (is_cond_w),
    .opt      (opt_w),
    .crv      (cr),
    .cr_idx   (idx_w),
    .ctr_in   (ctr),
    .ctr_next (ctr_next_w),
    .dec_en   (dec_en_w),
    .take     (taken_w)
  );

  bru_target u_tgt (
    .form    (form_w),
    .iw      (instr),
    .abs_sel (abs_w),
    .pc_in   (pc),
    .ctr_in  (ctr),
    .lr_in   (lr),
    .target  (target_w),
    .seq_pc  (seq_w)
  );

  assign npc_w  = taken_w ? target_w : seq_w;
  assign rsvd_w = opt_w.rsvd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
      ctr_we    <= 1'b0;
      ctr_wdata <= '0;
      lr_we     <= 1'b0;
      lr_wdata  <= '0;
      hint      <= 1'b0;
      reserved  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      ctr_we    <= in_valid & dec_en_w;
      lr_we     <= in_valid & link_w;
      if (in_valid) begin
        taken     <= taken_w;
        next_pc   <= npc_w;
        ctr_wdata <= ctr_next_w;
        lr_wdata  <= seq_w;
        hint      <= hint_w;
        reserved  <= rsvd_w;
      end
    end
  end

endmodule

// File: rtl/bru_unit_chk.sv
module bru_unit_chk
  import bru_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] ctr,
  input logic            out_valid,
  input logic            taken,
  input logic [XLEN-1:0] next_pc,
  input logic            ctr_we,
  input logic [XLEN-1:0] ctr_wdata,
  input logic            lr_we,
  input logic [XLEN-1:0] lr_wdata,
  input logic            reserved,
  input logic            dec_en_w,
  input logic            link_w,
  input logic            taken_w
);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !ctr_we && !lr_we));

  p_ctr_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_en_w) |=> (ctr_we && ctr_wdata == $past(ctr) - XLEN'(1)));

  p_reserved_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && reserved) |-> taken);

  p_link_save_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && link_w) |=> (lr_we && lr_wdata == $past(pc) + XLEN'(4)));

  p_fallthrough_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !taken_w) |=> (!taken && next_pc == $past(pc) + XLEN'(4)));

endmodule

bind bru_unit bru_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .pc        (pc),
  .ctr       (ctr),
  .out_valid (out_valid),
  .taken     (taken),
  .next_pc   (next_pc),
  .ctr_we    (ctr_we),
  .ctr_wdata (ctr_wdata),
  .lr_we     (lr_we),
  .lr_wdata  (lr_wdata),
  .reserved  (reserved),
  .dec_en_w  (dec_en_w),
  .link_w    (link_w),
  .taken_w   (taken_w)
);

// File: tb/bru_unit_tb_top.sv
module bru_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0, pc = '0, cr = '0, ctr = '0, lr = '0;
  logic        out_valid, taken, ctr_we, lr_we, hint, reserved;
  logic [31:0] next_pc, ctr_wdata, lr_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bru_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
    .cr(cr), .ctr(ctr), .lr(lr), .out_valid(out_valid), .taken(taken),
    .next_pc(next_pc), .ctr_we(ctr_we), .ctr_wdata(ctr_wdata), .lr_we(lr_we),
    .lr_wdata(lr_wdata), .hint(hint), .reserved(reserved)
  );

  function automatic logic [31:0] enc_cond(input logic [4:0] bo, input logic [4:0] bi,
                                           input logic [15:0] d, input logic aa,
                                           input logic lk);
    return {6'd16, bo, bi, d[15:2], aa, lk};
  endfunction

  function automatic logic [31:0] enc_direct(input logic [25:0] li, input logic aa,
                                             input logic lk);
    return {6'd18, li[25:2], aa, lk};
  endfunction

  function automatic logic [31:0] enc_ext(input logic [4:0] bo, input logic [4:0] bi,
                                          input logic [9:0] xo, input logic lk);
    return {6'd19, bo, bi, 5'd0, xo, lk};
  endfunction

  typedef struct packed {
    logic [31:0] iw;
    logic [31:0] ctr;
    logic [31:0] lr;
    logic        tk;
    logic [31:0] npc;
    logic        cwe;
    logic [31:0] cval;
    logic        lwe;
    logic        hnt;
    logic        rsv;
  } vec_t;

  localparam logic [31:0] PC0 = 32'h0000_1000;
  localparam logic [31:0] CR0 = 32'hA000_0000; // index0=1, index1=0, index2=1
  localparam int NV = 22;

  localparam vec_t TBL [NV] = '{
    // R3 R2: bit set test on index 0, taken
    '{enc_cond(5'b01100, 5'd0, 16'h0040, 1'b0, 1'b0), 32'd5, 32'h2000, 1'b1, 32'h1040, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0},
    // R3 R10: bit set test on index 1 (clear), not taken
    '{enc_cond(5'b01100, 5'd1, 16'h0040, 1'b0, 1'b0), 32'd5, 32'h2000, 1'b0, 32'h1004, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0},
    // R6 R2: clear test, negative offset, hint set
    '{enc_cond(5'b00101, 5'd1, 16'hFFF8, 1'b0, 1'b0), 32'd5, 32'h2000, 1'b1, 32'h0FF8, 1'b0, 32'd0, 1'b0, 1'b1, 1'b0},
    // R4: decrement, non-zero wanted, 5->4
    '{enc_cond(5'b10000, 5'd0, 16'h0020, 1'b0, 1'b0), 32'd5, 32'h2000, 1'b1, 32'h1020, 1'b1, 32'd4, 1'b0, 1'b0, 1'b0},
    // R4: decrement 1->0, non-zero wanted, written back although not taken
    '{enc_cond(5'b10000, 5'd0, 16'h0020, 1'b0, 1'b0), 32'd1, 32'h2000, 1'b0, 32'h1004, 1'b1, 32'd0, 1'b0, 1'b0, 1'b0},
    // R4: decrement 1->0, zero wanted
    '{enc_cond(5'b10010, 5'd0, 16'h0020, 1'b0, 1'b0), 32'd1, 32'h2000, 1'b1, 32'h1020, 1'b1, 32'd0, 1'b0, 1'b0, 1'b0},
    // R3: count non-zero and bit clear
    '{enc_cond(5'b00000, 5'd1, 16'h0020, 1'b0, 1'b0), 32'd3, 32'h2000, 1'b1, 32'h1020, 1'b1, 32'd2, 1'b0, 1'b0, 1'b0},
    // R3: count non-zero and bit set fails on a clear bit
    '{enc_cond(5'b01000, 5'd1, 16'h0020, 1'b0, 1'b0), 32'd3, 32'h2000, 1'b0, 32'h1004, 1'b1, 32'd2, 1'b0, 1'b0, 1'b0},
    // R3: count zero and bit set (index 2)
    '{enc_cond(5'b01010, 5'd2, 16'h0020, 1'b0, 1'b0), 32'd1, 32'h2000, 1'b1, 32'h1020, 1'b1, 32'd0, 1'b0, 1'b0, 1'b0},
    // R3: count zero wanted but 2->1
    '{enc_cond(5'b00010, 5'd1, 16'h0020, 1'b0, 1'b0), 32'd2, 32'h2000, 1'b0, 32'h1004, 1'b1, 32'd1, 1'b0, 1'b0, 1'b0},
    // R3 R6 R9: always, absolute, link
    '{enc_cond(5'b10100, 5'd0, 16'h0100, 1'b1, 1'b1), 32'd5, 32'h2000, 1'b1, 32'h0100, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0},
    // R5: code 1100
    '{enc_cond(5'b11000, 5'd1, 16'h0010, 1'b0, 1'b0), 32'd5, 32'h2000, 1'b1, 32'h1010, 1'b0, 32'd0, 1'b0, 1'b0, 1'b1},
    // R5: code 0011
    '{enc_cond(5'b00110, 5'd1, 16'h0010, 1'b0, 1'b0), 32'd5, 32'h2000, 1'b1, 32'h1010, 1'b0, 32'd0, 1'b0, 1'b0, 1'b1},
    // R7 R9: direct forward with link
    '{enc_direct(26'h0000400, 1'b0, 1'b1), 32'd5, 32'h2000, 1'b1, 32'h1400, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0},
    // R7: direct backward, sign from bit 25
    '{enc_direct(26'h3FFF800, 1'b0, 1'b0), 32'd5, 32'h2000, 1'b1, 32'h0800, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0},
    // R7: direct absolute
    '{enc_direct(26'h0010000, 1'b1, 1'b0), 32'd5, 32'h2000, 1'b1, 32'h0001_0000, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0},
    // R8 R9: via link, low bits cleared, old link used, link rewritten
    '{enc_ext(5'b10101, 5'd0, 10'd16, 1'b1), 32'd5, 32'h2003, 1'b1, 32'h2000, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0},
    // R8: via count, bit set taken
    '{enc_ext(5'b01100, 5'd2, 10'd528, 1'b0), 32'h3007, 32'h2000, 1'b1, 32'h3004, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0},
    // R8 R10: via count, bit clear so not taken
    '{enc_ext(5'b01100, 5'd1, 10'd528, 1'b0), 32'h3007, 32'h2000, 1'b0, 32'h1004, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0},
    // R11: other primary opcode with bit 0 set
    '{32'h7C00_0001, 32'd5, 32'h2000, 1'b0, 32'h1004, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0},
    // R11: opcode 19 with unrelated extended code
    '{enc_ext(5'b10101, 5'd0, 10'd150, 1'b1), 32'd5, 32'h2000, 1'b0, 32'h1004, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0},
    // R4 R8: via link with decrement 2->1
    '{enc_ext(5'b10000, 5'd0, 10'd16, 1'b0), 32'd2, 32'h4000, 1'b1, 32'h4000, 1'b1, 32'd1, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input int idx, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (case %0d): actual %h expected %h", tag, idx, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset out_valid", -1, {31'd0, out_valid}, 32'd0);
    chk("R1 reset taken", -1, {31'd0, taken}, 32'd0);
    chk("R1 reset next_pc", -1, next_pc, 32'd0);
    chk("R1 reset write enables", -1, {30'd0, ctr_we, lr_we}, 32'd0);
    chk("R1 reset flags", -1, {30'd0, hint, reserved}, 32'd0);
    rst_n = 1'b1;
    pc = PC0;
    cr = CR0;

    for (int i = 0; i < NV; i++) begin
      instr = TBL[i].iw;
      ctr = TBL[i].ctr;
      lr = TBL[i].lr;
      in_valid = 1'b1;
      @(negedge clk);
      chk("R1 out_valid", i, {31'd0, out_valid}, 32'd1);
      chk("R3 taken", i, {31'd0, taken}, {31'd0, TBL[i].tk});
      chk("R10 next_pc", i, next_pc, TBL[i].npc);
      chk("R4 ctr_we", i, {31'd0, ctr_we}, {31'd0, TBL[i].cwe});
      if (TBL[i].cwe) chk("R4 ctr_wdata", i, ctr_wdata, TBL[i].cval);
      chk("R9 lr_we", i, {31'd0, lr_we}, {31'd0, TBL[i].lwe});
      if (TBL[i].lwe) chk("R9 lr_wdata", i, lr_wdata, PC0 + 32'd4);
      chk("R2 hint", i, {31'd0, hint}, {31'd0, TBL[i].hnt});
      chk("R5 reserved", i, {31'd0, reserved}, {31'd0, TBL[i].rsv});
    end

    // R1: an idle cycle after a linking, decrementing word writes nothing
    instr = enc_cond(5'b00000, 5'd1, 16'h0020, 1'b0, 1'b1);
    ctr = 32'd3;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R9 lr_we before idle", 100, {31'd0, lr_we}, 32'd1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R1 idle out_valid", 101, {31'd0, out_valid}, 32'd0);
    chk("R1 idle write enables", 101, {30'd0, ctr_we, lr_we}, 32'd0);

    // R7: relative target wraps past the top of the address space
    pc = 32'hFFFF_FFF0;
    instr = enc_direct(26'h0000020, 1'b0, 1'b0);
    in_valid = 1'b1;
    @(negedge clk);
    chk("R7 wrap next_pc", 102, next_pc, 32'h0000_0010);

    // R4: count wraps from zero to all ones, non-zero wanted -> taken
    pc = PC0;
    ctr = 32'd0;
    instr = enc_cond(5'b10000, 5'd0, 16'h0008, 1'b0, 1'b0);
    @(negedge clk);
    chk("R4 wrap ctr_wdata", 103, ctr_wdata, 32'hFFFF_FFFF);
    chk("R4 wrap taken", 103, {31'd0, taken}, 32'd1);

    // R2: highest condition index reads bit 0 of the register
    cr = 32'h0000_0001;
    instr = enc_cond(5'b01100, 5'd31, 16'h0008, 1'b0, 1'b0);
    @(negedge clk);
    chk("R2 index 31 taken", 104, {31'd0, taken}, 32'd1);
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule